// File: doc/BRIEF.md
# Relocating Buffer Base Register Bank

This block holds the start addresses of the buffer regions in packet memory, one per buffer size class, and turns a (size class, buffer number) pair into a physical packet-memory address. Software writes and reads the bases over a simple register bus. Each value is relocated when it is stored: the current packet-memory real base and offset are added on write and taken off again on read. A buffer lookup therefore needs only one addition and one shift.

Two modes are supported. In virtual mode each size class has its own base register and a fixed buffer size from a parameter table. A low nibble of 0xF marks a class as unused, and any lookup through that class is flagged. In real mode only base register 0 is used. Its low nibble is ignored, and the buffer size comes from an input. When the real base or the offset changes, the stored bases become stale. A per-register stale bit guards lookups until software rewrites that register. A write whose relocated value breaks the buffer-size alignment is still stored, but it raises a sticky status bit.

Top module: `buf_base_bank`

## Requirements
- R1: After reset, every base register holds PM_BASE_RST + PM_OFS_RST + 0xF (0x0020000F by default). With the relocation inputs at their reset values, each base reads back 0x0000000F and the status register reads 0.
- R2: Writing value w to base register i (offset 0xD20 + 4*i, i = 0..4) stores w + pm_base_i + pm_ofs_i, sampled in the write cycle.
- R3: Reading base register i returns the stored value minus pm_base_i minus pm_ofs_i. Software reads back the value it wrote while the relocation inputs are unchanged.
- R4: In virtual mode, a lookup through class c (0..4) uses base register c and buffer size 2^CLS_LG2[c]. The address is {base[31:4],4'h0} + (index << CLS_LG2[c]), with err low.
- R5: In virtual mode, a lookup through a class whose stored low nibble is 0xF returns err high and address 0.
- R6: In virtual mode, a lookup with class 5, 6 or 7 returns err high and address 0.
- R7: In real mode, every lookup uses base register 0, whatever the class. The low nibble of that register is ignored, and the buffer size is 2^real_lg2_i.
- R8: Any change of pm_base_i or pm_ofs_i sets the stale bit of every base register; status bit 8+i holds the stale bit of register i. Writing register i clears its stale bit. A lookup through a stale register returns err high and address 0.
- R9: A base write whose relocated value has a nonzero bit in [CLS_LG2[i]-1:4] still stores the value and sets status bit 0. That bit stays set until software writes 1 to bit 0 of the status register at offset 0xD34.
- R10: Each lookup request produces xlat_vld_o exactly one clock later, together with that request's address and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| pm_base_i | input | 32 | Packet-memory real base |
| pm_ofs_i | input | 32 | Packet-memory offset |
| real_mode_i | input | 1 | 1 selects real memory mode |
| real_lg2_i | input | 5 | log2 of the real-mode buffer size |
| xlat_req_i | input | 1 | Lookup request |
| xlat_cls_i | input | 3 | Size class of the lookup |
| xlat_idx_i | input | 16 | Buffer number |
| xlat_vld_o | output | 1 | Lookup result valid |
| xlat_addr_o | output | 32 | Physical address (0 on error) |
| xlat_err_o | output | 1 | Lookup error |

## Verification
The bench builds the block with its default parameters. The class sizes are 128, 256, 1024, 4096 and 256 bytes, and the relocation reset is 0x00200000 plus 0. With these values, a 0x100 offset change breaks 4096-byte alignment but keeps 256-byte alignment, so one offset setting exercises both the sticky alignment flag and a clean relocation. The 256-byte real-mode size lets a real-mode lookup land on addresses distinct from every virtual class. A scoreboard queue holds the expected address and error for every lookup and checks them against the one-cycle-late result. Register reads are checked directly after each relocation change, and they show the reverse adjustment drifting once the stored bases go stale.

// File: rtl/bbb_pkg.sv
package bbb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LG_W   = 5;
endpackage

// File: rtl/bbb_regfile.sv
module bbb_regfile
  import bbb_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 5,
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'hD20,
  parameter logic [NUM_REGS*LG_W-1:0] CLS_LG2 = {5'd8, 5'd12, 5'd10, 5'd8, 5'd7},
  parameter logic [DATA_W-1:0] PM_BASE_RST = 32'h0020_0000,
  parameter logic [DATA_W-1:0] PM_OFS_RST  = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] pm_base_i,
  input  logic [DATA_W-1:0] pm_ofs_i,
  output logic [DATA_W-1:0] base_o [NUM_REGS],
  output logic [NUM_REGS-1:0] stale_o
);
  localparam int unsigned WI_W = ADDR_W - 2;
  localparam logic [WI_W-1:0] STAT_WI = WI_W'(NUM_REGS);
  localparam logic [DATA_W-1:0] BASE_RST = PM_BASE_RST + PM_OFS_RST + 32'hF;

  logic [ADDR_W-1:0] rel;
  logic [WI_W-1:0]   widx;
  logic              hit_base, hit_stat, pm_chg, misalign;
  logic [DATA_W-1:0] adj, rd_base, sel_mask;
  logic [DATA_W-1:0] base_q [NUM_REGS];
  logic [DATA_W-1:0] amask  [NUM_REGS];
  logic [NUM_REGS-1:0] stale_q, wsel;
  logic [DATA_W-1:0] pm_base_q, pm_ofs_q;
  logic              align_q;

  assign rel      = addr_i - BANK_BASE;
  assign widx     = rel[ADDR_W-1:2];
  assign hit_base = (rel[1:0] == 2'b00) && (widx < STAT_WI);
  assign hit_stat = (rel[1:0] == 2'b00) && (widx == STAT_WI);
  assign adj      = wdata_i + pm_base_i + pm_ofs_i;
  assign pm_chg   = (pm_base_i != pm_base_q) || (pm_ofs_i != pm_ofs_q);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [LG_W-1:0] LG = CLS_LG2[i*LG_W +: LG_W];
    assign amask[i] = ((32'd1 << LG) - 32'd1) & 32'hFFFF_FFF0;
    assign wsel[i]  = we_i && hit_base && (widx == WI_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[i]  <= BASE_RST;
        stale_q[i] <= 1'b0;
      end else begin
        if (wsel[i]) base_q[i] <= adj;
        if (wsel[i])     stale_q[i] <= 1'b0;
        else if (pm_chg) stale_q[i] <= 1'b1;
      end
    end

    // R8
    wr_clears_stale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wsel[i] |=> !stale_q[i]);
    // R8
    chg_sets_stale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pm_chg && !wsel[i]) |=> stale_q[i]);
  end

  always_comb begin
    rd_base  = '0;
    sel_mask = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (widx == WI_W'(i)) begin
        rd_base  = base_q[i];
        sel_mask = amask[i];
      end
    end
  end

  assign misalign = we_i && hit_base && |(adj & sel_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pm_base_q <= PM_BASE_RST;
      pm_ofs_q  <= PM_OFS_RST;
      align_q   <= 1'b0;
    end else begin
      pm_base_q <= pm_base_i;
      pm_ofs_q  <= pm_ofs_i;
      if (misalign)                               align_q <= 1'b1;
      else if (we_i && hit_stat && wdata_i[0])    align_q <= 1'b0;
    end
  end

  // R9
  align_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_q && !(we_i && hit_stat)) |=> align_q);

  always_comb begin
    if (hit_base)      rdata_o = rd_base - pm_base_i - pm_ofs_i;
    else if (hit_stat) rdata_o = (DATA_W'(stale_q) << 8) | DATA_W'(align_q);
    else               rdata_o = '0;
  end

  assign base_o  = base_q;
  assign stale_o = stale_q;
endmodule

// File: rtl/bbb_xlat.sv
module bbb_xlat
  import bbb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 5,
  parameter int unsigned IDX_W    = 16,
  parameter logic [NUM_REGS*LG_W-1:0] CLS_LG2 = {5'd8, 5'd12, 5'd10, 5'd8, 5'd7}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] base_i [NUM_REGS],
  input  logic [NUM_REGS-1:0] stale_i,
  input  logic              real_mode_i,
  input  logic [LG_W-1:0]   real_lg2_i,
  input  logic              req_i,
  input  logic [2:0]        cls_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] addr_o,
  output logic              err_o
);
  logic [DATA_W-1:0] base_sel, addr_d;
  logic [LG_W-1:0]   lg_sel;
  logic              cls_ok, stale_sel, err_d;

  always_comb begin
    base_sel  = base_i[0];
    stale_sel = stale_i[0];
    lg_sel    = real_lg2_i;
    cls_ok    = real_mode_i;
    if (!real_mode_i) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (cls_i == 3'(i)) begin
          base_sel  = base_i[i];
          stale_sel = stale_i[i];
          lg_sel    = CLS_LG2[i*LG_W +: LG_W];
          cls_ok    = 1'b1;
        end
      end
    end
    err_d  = !cls_ok || stale_sel || (!real_mode_i && base_sel[3:0] == 4'hF);
    addr_d = {base_sel[DATA_W-1:4], 4'h0} + (DATA_W'(idx_i) << lg_sel);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        err_o  <= err_d;
        addr_o <= err_d ? '0 : addr_d;
      end
    end
  end

  // R10
  vld_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  // R6
  bad_cls_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !real_mode_i && cls_i >= 3'(NUM_REGS)) |=> (err_o && addr_o == '0));
  // R8
  stale_real_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && real_mode_i && stale_i[0]) |=> err_o);
endmodule

// File: rtl/buf_base_bank.sv
module buf_base_bank
  import bbb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 5,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned IDX_W    = 16,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'hD20,
  parameter logic [NUM_REGS*LG_W-1:0] CLS_LG2 = {5'd8, 5'd12, 5'd10, 5'd8, 5'd7},
  parameter logic [DATA_W-1:0] PM_BASE_RST = 32'h0020_0000,
  parameter logic [DATA_W-1:0] PM_OFS_RST  = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [DATA_W-1:0] pm_base_i,
  input  logic [DATA_W-1:0] pm_ofs_i,
  input  logic              real_mode_i,
  input  logic [LG_W-1:0]   real_lg2_i,
  input  logic              xlat_req_i,
  input  logic [2:0]        xlat_cls_i,
  input  logic [IDX_W-1:0]  xlat_idx_i,
  output logic              xlat_vld_o,
  output logic [DATA_W-1:0] xlat_addr_o,
  output logic              xlat_err_o
);
  logic [DATA_W-1:0]   base_w [NUM_REGS];
  logic [NUM_REGS-1:0] stale_w;

  bbb_regfile #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE),
    .CLS_LG2(CLS_LG2), .PM_BASE_RST(PM_BASE_RST), .PM_OFS_RST(PM_OFS_RST)
  ) u_regfile (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pm_base_i, .pm_ofs_i,
    .base_o(base_w), .stale_o(stale_w)
  );

  bbb_xlat #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CLS_LG2(CLS_LG2)
  ) u_xlat (
    .clk_i, .rst_ni,
    .base_i(base_w), .stale_i(stale_w),
    .real_mode_i, .real_lg2_i,
    .req_i(xlat_req_i), .cls_i(xlat_cls_i), .idx_i(xlat_idx_i),
    .vld_o(xlat_vld_o), .addr_o(xlat_addr_o), .err_o(xlat_err_o)
  );
endmodule

// File: tb/buf_base_bank_bench.sv
module buf_base_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = 12'h0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pm_base = 32'h0020_0000, pm_ofs = 32'h0;
  logic        real_mode = 1'b0;
  logic [4:0]  real_lg2 = 5'd8;
  logic        req = 1'b0;
  logic [2:0]  cls = '0;
  logic [15:0] idx = '0;
  logic        vld, err;
  logic [31:0] xaddr;

  int tests = 0, fails = 0;
  typedef struct { logic err; logic [31:0] addr; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  buf_base_bank u_buf_base_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pm_base_i(pm_base), .pm_ofs_i(pm_ofs),
    .real_mode_i(real_mode), .real_lg2_i(real_lg2),
    .xlat_req_i(req), .xlat_cls_i(cls), .xlat_idx_i(idx),
    .xlat_vld_o(vld), .xlat_addr_o(xaddr), .xlat_err_o(err)
  );

  function automatic logic [11:0] reg_off(int i);
    return 12'hD20 + 12'(4 * i);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  // driver: pushes expected result, monitor pops it
  task automatic lookup(string tag, logic rm, logic [2:0] c, logic [15:0] n,
                        logic e, logic [31:0] a);
    exp_t x;
    @(posedge clk); #1;
    real_mode = rm; cls = c; idx = n; req = 1'b1;
    x.err = e; x.addr = e ? 32'h0 : a; x.tag = tag;
    q.push_back(x);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R10: unexpected result actual %h expected none", xaddr);
      end else begin
        exp_t x;
        x = q.pop_front();
        chk({x.tag, " err"}, 32'(err), 32'(x.err));
        chk({x.tag, " addr"}, xaddr, x.addr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset readback and status
    for (int i = 0; i < 5; i++) rd_chk("R1 reset readback", reg_off(i), 32'hF);
    rd_chk("R1 reset status", 12'hD34, 32'h0);
    // R1 R7 reset stored value via real mode, class ignored, nibble ignored
    lookup("R1 R7 real after reset", 1'b1, 3'd3, 16'd3, 1'b0, 32'h0020_0300);
    // R5 sentinel at reset
    lookup("R5 sentinel cls1", 1'b0, 3'd1, 16'd1, 1'b1, 32'h0);
    // R6 invalid classes
    lookup("R6 cls5", 1'b0, 3'd5, 16'd0, 1'b1, 32'h0);
    lookup("R6 cls7", 1'b0, 3'd7, 16'd2, 1'b1, 32'h0);

    // R2 R3 R4 write reg1, readback, lookup
    wr(reg_off(1), 32'h0000_1000);
    rd_chk("R3 readback reg1", reg_off(1), 32'h0000_1000);
    lookup("R2 R4 cls1 idx5", 1'b0, 3'd1, 16'd5, 1'b0, 32'h0020_1500);
    wr(reg_off(3), 32'h0001_0000);
    lookup("R4 cls3 idx2", 1'b0, 3'd3, 16'd2, 1'b0, 32'h0021_2000);
    // back-to-back style: lookups through two classes
    lookup("R10 cls1 idx0", 1'b0, 3'd1, 16'd0, 1'b0, 32'h0020_1000);

    // R8 offset change makes everything stale
    @(posedge clk); #1 pm_ofs = 32'h0000_0100;
    @(posedge clk);
    rd_chk("R8 status stale all", 12'hD34, 32'h0000_1F00);
    rd_chk("R3 readback drifts when stale", reg_off(1), 32'h0000_0F00);
    lookup("R8 stale cls1", 1'b0, 3'd1, 16'd1, 1'b1, 32'h0);
    lookup("R8 stale real reg0", 1'b1, 3'd0, 16'd1, 1'b1, 32'h0);
    wr(reg_off(1), 32'h0000_1000);
    rd_chk("R8 rewrite clears bit9", 12'hD34, 32'h0000_1D00);
    lookup("R2 R8 cls1 relocated", 1'b0, 3'd1, 16'd2, 1'b0, 32'h0020_1300);

    // R9 misaligned write to 4096-byte class
    wr(reg_off(3), 32'h0000_2000);
    rd_chk("R9 align bit set", 12'hD34, 32'h0000_1501);
    rd_chk("R9 stored anyway", reg_off(3), 32'h0000_2000);
    lookup("R9 misaligned lookup", 1'b0, 3'd3, 16'd1, 1'b0, 32'h0020_3100);
    wr(reg_off(2), 32'h0000_4000);
    rd_chk("R9 sticky", 12'hD34, 32'h0000_1101);
    wr(12'hD34, 32'h0000_0000);
    rd_chk("R9 write 0 no clear", 12'hD34, 32'h0000_1101);
    wr(12'hD34, 32'h0000_0001);
    rd_chk("R9 w1c", 12'hD34, 32'h0000_1100);

    // R5 sentinel written by software
    wr(reg_off(2), 32'h0000_400F);
    lookup("R5 sentinel cls2", 1'b0, 3'd2, 16'd1, 1'b1, 32'h0);

    // R7 real mode: reg0 nibble ignored, class ignored, real size
    wr(reg_off(0), 32'h0000_000F);
    rd_chk("R3 readback reg0", reg_off(0), 32'h0000_000F);
    lookup("R7 real nibble ignored", 1'b1, 3'd6, 16'd1, 1'b0, 32'h0020_0200);
    lookup("R5 reg0 virtual sentinel", 1'b0, 3'd0, 16'd1, 1'b1, 32'h0);
    @(posedge clk); #1 real_lg2 = 5'd12;
    lookup("R7 real size 4096", 1'b1, 3'd2, 16'd3, 1'b0, 32'h0020_3100);

    repeat (3) @(posedge clk);
    #1 chk("R10 queue drained", 32'(q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule